// File: doc/BRIEF.md
# Message Queue Pointer Interrupt Unit

This block keeps the head and tail pointers of four message queues: processor-to-processor messages, device messages, resumable errors and non-resumable errors. Software reads and writes the eight pointers through an indexed register port. Each of the first three queues has a level interrupt that stays high while its head and tail pointers hold different values, which means the queue still holds unconsumed entries. The non-resumable error queue stores its pointers in the same way but never raises an interrupt.

The hardware that appends entries to a queue is outside this block. In its place there is a separate tail-update port. That port writes one queue's tail and does not use the software index. The queue memory and the message formats are also outside the block.

Top module: `mq_irq_top`

## Requirements
- R1: Index encoding on the register port: index bit 0 selects head (0) or tail (1), and index bits 2:1 select the queue, with 0 = processor messages, 1 = device messages, 2 = resumable error and 3 = non-resumable error.
- R2: A register write with wr_en_i stores wr_data_i into the selected pointer at the next clock edge. rd_data_o is combinational and returns the stored value of the pointer that rd_idx_i selects, unchanged.
- R3: irq_cpu_o is high exactly when queue 0's head and tail differ, one cycle after the pointer write that caused the change.
- R4: irq_dev_o follows the same rule for queue 1.
- R5: irq_rerr_o follows the same rule for queue 2.
- R6: Queue 3's pointers are stored and read back, but no output changes when they are written.
- R7: The tail port (hw_tail_we_i, hw_tail_q_i, hw_tail_i) writes the tail of the chosen queue, and the interrupt is re-evaluated exactly as for a register write. If both ports target the same pointer in the same cycle, the register write wins.
- R8: After reset all pointers are zero and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Write pointer index |
| wr_data_i | input | PTR_W | Write data |
| rd_idx_i | input | 3 | Read pointer index |
| rd_data_o | output | PTR_W | Read data |
| hw_tail_we_i | input | 1 | Tail-update strobe |
| hw_tail_q_i | input | 2 | Tail-update queue select |
| hw_tail_i | input | PTR_W | Tail-update value |
| irq_cpu_o | output | 1 | Processor message queue non-empty |
| irq_dev_o | output | 1 | Device message queue non-empty |
| irq_rerr_o | output | 1 | Resumable error queue non-empty |

## Verification
The hardest case to reach is a collision: the register port and the tail port both target the same tail in the same cycle, so the priority decides both the stored value and the interrupt level. The bench drives both ports in one cycle with different values. One value equals the head and the other does not, so a wrong priority shows up on the interrupt as well as on readback. The bench also checks that a queue leaves its interrupt high when only its head moves and the pointers stay unequal.

// File: rtl/mq_irq_pkg.sv
package mq_irq_pkg;
  localparam int unsigned NUM_Q   = 4;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned Q_W     = 2;
  localparam int unsigned NUM_IRQ = 3;
  typedef enum logic [Q_W-1:0] {
    Q_CPU  = 2'd0,
    Q_DEV  = 2'd1,
    Q_RERR = 2'd2,
    Q_NERR = 2'd3
  } q_id_e;
endpackage

// File: rtl/mq_ptr_pair.sv
module mq_ptr_pair #(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_we_i,
  input  logic [PTR_W-1:0] head_d_i,
  input  logic             tail_we_i,
  input  logic [PTR_W-1:0] tail_d_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
    end else begin
      if (head_we_i) head_o <= head_d_i;
      if (tail_we_i) tail_o <= tail_d_i;
    end
  end

  assert_head_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_we_i |=> $stable(head_o));
  assert_tail_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tail_we_i |=> $stable(tail_o));
endmodule

// File: rtl/mq_irq_eval.sv
module mq_irq_eval #(
  parameter int unsigned PTR_W = 16,
  parameter bit          EN    = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] head_i,
  input  logic [PTR_W-1:0] tail_i,
  output logic             irq_o
);
  generate
    if (EN) begin : g_live
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= (head_i != tail_i);
      end
      assign irq_o = pend_q;
    end else begin : g_silent
      assign irq_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mq_irq_top.sv
module mq_irq_top
  import mq_irq_pkg::*;
#(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_idx_i,
  input  logic [PTR_W-1:0] wr_data_i,
  input  logic [2:0]       rd_idx_i,
  output logic [PTR_W-1:0] rd_data_o,
  input  logic             hw_tail_we_i,
  input  logic [1:0]       hw_tail_q_i,
  input  logic [PTR_W-1:0] hw_tail_i,
  output logic             irq_cpu_o,
  output logic             irq_dev_o,
  output logic             irq_rerr_o
);
  logic [PTR_W-1:0] head_w [NUM_Q];
  logic [PTR_W-1:0] tail_w [NUM_Q];
  logic [NUM_Q-1:0] irq_w;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic             sw_head, sw_tail, hw_hit, t_we;
    logic [PTR_W-1:0] t_d;
    assign sw_head = wr_en_i && (wr_idx_i == IDX_W'(2*q));
    assign sw_tail = wr_en_i && (wr_idx_i == IDX_W'(2*q+1));
    assign hw_hit  = hw_tail_we_i && (hw_tail_q_i == Q_W'(q));
    assign t_we    = sw_tail || hw_hit;
    assign t_d     = sw_tail ? wr_data_i : hw_tail_i;  // register port wins

    mq_ptr_pair #(.PTR_W(PTR_W)) i_pair (
      .clk_i, .rst_ni,
      .head_we_i(sw_head), .head_d_i(wr_data_i),
      .tail_we_i(t_we),    .tail_d_i(t_d),
      .head_o(head_w[q]),  .tail_o(tail_w[q])
    );

    mq_irq_eval #(.PTR_W(PTR_W), .EN(q != int'(Q_NERR))) i_eval (
      .clk_i, .rst_ni,
      .head_i(head_w[q]), .tail_i(tail_w[q]),
      .irq_o(irq_w[q])
    );
  end

  always_comb begin
    rd_data_o = rd_idx_i[0] ? tail_w[rd_idx_i[2:1]] : head_w[rd_idx_i[2:1]];
  end

  assign irq_cpu_o  = irq_w[Q_CPU];
  assign irq_dev_o  = irq_w[Q_DEV];
  assign irq_rerr_o = irq_w[Q_RERR];

  assert_cpu_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_w[0] != tail_w[0]) |=> irq_cpu_o);
  assert_dev_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_w[1] == tail_w[1]) |=> !irq_dev_o);
  assert_rerr_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_w[2] != tail_w[2]) |=> irq_rerr_o);
  assert_sw_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i[0] && hw_tail_we_i && hw_tail_q_i == wr_idx_i[2:1])
      |=> (tail_w[$past(wr_idx_i[2:1])] == $past(wr_data_i)));
  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_ni |-> !(irq_cpu_o || irq_dev_o || irq_rerr_o));
endmodule

// File: tb/test_mq_irq_top.sv
`timescale 1ns/1ps
module test_mq_irq_top;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, hw_we = 0;
  logic [2:0] wr_idx = 0, rd_idx = 0;
  logic [1:0] hw_q = 0;
  logic [W-1:0] wr_data = 0, hw_d = 0, rd_data;
  logic irq_cpu, irq_dev, irq_rerr;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mq_irq_top #(.PTR_W(W)) i_mq_irq_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .hw_tail_we_i(hw_we), .hw_tail_q_i(hw_q), .hw_tail_i(hw_d),
    .irq_cpu_o(irq_cpu), .irq_dev_o(irq_dev), .irq_rerr_o(irq_rerr));

  task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // drive on negedge, one edge captures, second edge updates irq
  task automatic wr(logic [2:0] idx, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic rd(logic [2:0] idx, output logic [W-1:0] v);
    rd_idx = idx; #1 v = rd_data;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    for (int i = 0; i < 8; i++) begin rd(3'(i), v); chk("R8 ptr", v, 0); end
    chk("R8 irq", {irq_cpu, irq_dev, irq_rerr}, 0);
  endtask

  task automatic t_readback();
    logic [W-1:0] v;
    for (int i = 0; i < 8; i++) wr(3'(i), W'(16'h1000 + i * 16'h111));
    for (int i = 0; i < 8; i++) begin rd(3'(i), v); chk("R1/R2 readback", v, W'(16'h1000 + i * 16'h111)); end
    for (int i = 0; i < 8; i++) wr(3'(i), 0);
    settle();
    chk("R2 cleared irq", {irq_cpu, irq_dev, irq_rerr}, 0);
  endtask

  task automatic t_cpu();
    wr(3'd1, 5);
    chk("R3 tail set irq", irq_cpu, 0);  // eval register not yet updated
    settle();
    chk("R3 irq high", irq_cpu, 1);
    chk("R3 others low", {irq_dev, irq_rerr}, 0);
    wr(3'd0, 3); settle();
    chk("R3 head moved still pending", irq_cpu, 1);
    wr(3'd0, 5); settle();
    chk("R3 caught up", irq_cpu, 0);
  endtask

  task automatic t_dev_rerr();
    wr(3'd2, 7); settle();
    chk("R4 head ahead", {irq_cpu, irq_dev, irq_rerr}, 3'b010);
    wr(3'd3, 7); settle();
    chk("R4 equal", irq_dev, 0);
    wr(3'd5, 9); settle();
    chk("R5 pending", {irq_cpu, irq_dev, irq_rerr}, 3'b001);
    wr(3'd4, 9); settle();
    chk("R5 equal", irq_rerr, 0);
  endtask

  task automatic t_nerr();
    logic [W-1:0] v;
    wr(3'd7, 16'hbeef); settle(); settle();
    chk("R6 silent", {irq_cpu, irq_dev, irq_rerr}, 0);
    rd(3'd7, v); chk("R6 tail stored", v, 16'hbeef);
    wr(3'd6, 16'h0042); settle();
    chk("R6 silent head", {irq_cpu, irq_dev, irq_rerr}, 0);
    rd(3'd6, v); chk("R6 head stored", v, 16'h0042);
  endtask

  task automatic t_hw();
    logic [W-1:0] v;
    @(negedge clk); hw_we = 1; hw_q = 2'd0; hw_d = 6;
    @(negedge clk); hw_we = 0;
    settle();
    chk("R7 hw tail irq", irq_cpu, 1);
    rd(3'd1, v); chk("R7 hw tail value", v, 6);
    // collision: sw writes 6 (== head 5? no) -> use head value 5 to clear
    @(negedge clk); wr_en = 1; wr_idx = 3'd1; wr_data = 5; hw_we = 1; hw_q = 2'd0; hw_d = 16'h77;
    @(negedge clk); wr_en = 0; hw_we = 0;
    settle();
    rd(3'd1, v); chk("R7 sw wins value", v, 5);
    chk("R7 sw wins irq", irq_cpu, 0);
    // hw to other queue concurrently with sw on a different pointer
    @(negedge clk); wr_en = 1; wr_idx = 3'd2; wr_data = 1; hw_we = 1; hw_q = 2'd2; hw_d = 4;
    @(negedge clk); wr_en = 0; hw_we = 0;
    settle();
    chk("R7 both ports", {irq_dev, irq_rerr}, 2'b11);
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_cpu();
    t_dev_rerr();
    t_nerr();
    t_hw();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule